// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block sits between a set of free-running source clocks and the output pins of a clock generator. It gates five groups of outputs: processor clocks, one always-running bus clock, the remaining bus clocks, memory clocks and fixed-rate reference clocks. Each output has its own enable bit. A strap input decides whether four shared pins act as active-low stop and power-down controls or carry four of the memory clocks as outputs. A separate tristate control drops every output enable.

Gating never changes while a clock is high. The stop and power-down pins are sampled on the rising edge of the always-running bus clock. Each group's gate flops then take the sampled request on the falling edge of that group's own clock. A stopped output therefore stays low, and a restarted output begins with a complete high phase. The worst-case latency is set by one bus clock edge plus one falling edge of the target clock.

Top module: `clkstop_ctrl`

## Requirements
- R1: An output toggles with its source clock only while its enable bit is 1 and no stop or power-down control applies to its group. Otherwise it is held low.
- R2: With the strap at 0, a low level on shared_pin_n[0] stops the processor group. All other groups keep running.
- R3: With the strap at 0, a low level on shared_pin_n[1] stops the bus clock group. The always-running bus clock output keeps toggling.
- R4: With the strap at 0, a low level on shared_pin_n[2] stops the memory clock group.
- R5: With the strap at 0, a low level on shared_pin_n[3] holds every output low, whatever levels the other shared pins have. This includes the always-running bus clock and the reference clocks.
- R6: With the strap at 1, the shared pins have no effect. Memory outputs 8 to 11 then run with their output enables high. With the strap at 0, those four outputs are held low and their output enables are low.
- R7: A gate changes only while its source clock is low. Every high pulse on an output lasts exactly half of its source period.
- R8: Processor outputs stop, and resume with a rising edge, within two processor periods of the bus clock rising edge that samples the pin change. Bus group outputs already reflect the new state at the next bus clock rising edge after that sampling edge.
- R9: With tri_en at 1, every output enable is 0.
- R10: During reset every output is low. After reset is released, enabled outputs start by themselves within the latency of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | Processor source clock |
| pci_src | input | 1 | Free-running bus source clock; also the pin sampling clock |
| sdr_src | input | 1 | Memory source clock |
| ref_src | input | 1 | Reference source clock |
| mode_strap | input | 1 | 0: shared pins are stop controls; 1: shared pins are memory clock outputs |
| shared_pin_n | input | 4 | Active-low controls: [0] processor stop, [1] bus stop, [2] memory stop, [3] power-down |
| tri_en | input | 1 | 1 drops all output enables |
| en_cpu | input | N_CPU | Per-output enables, processor group |
| en_pcif | input | 1 | Enable of the always-running bus clock |
| en_pci | input | N_PCI | Per-output enables, bus group |
| en_sdr | input | N_SDR | Per-output enables, memory group |
| en_ref | input | N_REF | Per-output enables, reference group |
| cpu_clk | output | N_CPU | Gated processor clocks |
| pcif_clk | output | 1 | Always-running bus clock, gated only by enable and power-down |
| pci_clk | output | N_PCI | Gated bus clocks |
| sdr_clk | output | N_SDR | Gated memory clocks |
| ref_clk | output | N_REF | Gated reference clocks |
| cpu_oe | output | 1 | Output enable, processor group |
| pcif_oe | output | 1 | Output enable, always-running bus clock |
| pci_oe | output | 1 | Output enable, bus group |
| sdr_oe | output | N_SDR | Per-output enables, memory group |
| ref_oe | output | 1 | Output enable, reference group |

## Verification
Suppose a gate flop captured its request on the wrong edge. The output would then show a high pulse shorter than half a period on the very next toggle of the control, which a sampled pulse-width monitor catches within one source period. A wrong request decode, or a wrong strap decode, would show up as an output that toggles or stays low against the expected state. That is visible within a few reference periods of the pin change. A sampling stage that is one stage too slow would miss the latency windows. Those windows are measured from the sampling bus edge, to one bus period for the bus group and two periods for the processor group.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  // bit positions inside the shared active-low pin vector
  localparam int PIN_CPU = 0;
  localparam int PIN_PCI = 1;
  localparam int PIN_SDR = 2;
  localparam int PIN_PD  = 3;
  localparam int SHR_COUNT = 4;

  // a stop control is live only when the strap selects pin-input use
  function automatic logic stop_active(input logic strap, input logic pin_n);
    return !strap && !pin_n;
  endfunction

  // one output may run when enabled and neither power-down nor its group stop applies
  function automatic logic run_bit(input logic en, input logic pd_act, input logic grp_act);
    return en && !pd_act && !grp_act;
  endfunction

  // memory outputs that share a pin with the stop controls
  function automatic logic in_shared(input int idx, input int lo);
    return (idx >= lo) && (idx < lo + SHR_COUNT);
  endfunction
endpackage

// File: rtl/clkstop_sample.sv
`timescale 1ns/1ps
module clkstop_sample #(
  parameter int N_CPU  = 3,
  parameter int N_PCI  = 5,
  parameter int N_SDR  = 13,
  parameter int N_REF  = 4,
  parameter int SHR_LO = 8
) (
  input  logic             pci_src,
  input  logic             rst_n,
  input  logic             mode_strap,
  input  logic [3:0]       shared_pin_n,
  input  logic [N_CPU-1:0] en_cpu,
  input  logic             en_pcif,
  input  logic [N_PCI-1:0] en_pci,
  input  logic [N_SDR-1:0] en_sdr,
  input  logic [N_REF-1:0] en_ref,
  output logic [N_CPU-1:0] req_cpu,
  output logic             req_pcif,
  output logic [N_PCI-1:0] req_pci,
  output logic [N_SDR-1:0] req_sdr,
  output logic [N_REF-1:0] req_ref
);
  import clkstop_pkg::*;

  // decoded controls, brought out for the assertions
  logic pd_act, cpu_act, pci_act, sdr_act;
  assign pd_act  = stop_active(mode_strap, shared_pin_n[PIN_PD]);
  assign cpu_act = stop_active(mode_strap, shared_pin_n[PIN_CPU]);
  assign pci_act = stop_active(mode_strap, shared_pin_n[PIN_PCI]);
  assign sdr_act = stop_active(mode_strap, shared_pin_n[PIN_SDR]);

  logic [N_CPU-1:0] nxt_cpu;
  logic             nxt_pcif;
  logic [N_PCI-1:0] nxt_pci;
  logic [N_SDR-1:0] nxt_sdr;
  logic [N_REF-1:0] nxt_ref;

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    assign nxt_cpu[g] = run_bit(en_cpu[g], pd_act, cpu_act);
  end
  assign nxt_pcif = run_bit(en_pcif, pd_act, 1'b0);
  for (genvar g = 0; g < N_PCI; g++) begin : g_pci
    assign nxt_pci[g] = run_bit(en_pci[g], pd_act, pci_act);
  end
  for (genvar g = 0; g < N_SDR; g++) begin : g_sdr
    if (in_shared(g, SHR_LO)) begin : g_shr
      assign nxt_sdr[g] = run_bit(en_sdr[g], pd_act, sdr_act) && mode_strap;
    end else begin : g_own
      assign nxt_sdr[g] = run_bit(en_sdr[g], pd_act, sdr_act);
    end
  end
  for (genvar g = 0; g < N_REF; g++) begin : g_ref
    assign nxt_ref[g] = run_bit(en_ref[g], pd_act, 1'b0);
  end

  // single sampling stage on the free-running bus clock
  always_ff @(posedge pci_src or negedge rst_n) begin
    if (!rst_n) begin
      req_cpu  <= '0;
      req_pcif <= 1'b0;
      req_pci  <= '0;
      req_sdr  <= '0;
      req_ref  <= '0;
    end else begin
      req_cpu  <= nxt_cpu;
      req_pcif <= nxt_pcif;
      req_pci  <= nxt_pci;
      req_sdr  <= nxt_sdr;
      req_ref  <= nxt_ref;
    end
  end

  AST_CPU_STOP: assert property (@(posedge pci_src) disable iff (!rst_n)
    (!mode_strap && !shared_pin_n[0]) |=> (req_cpu == '0)); // R2
  AST_PCI_STOP: assert property (@(posedge pci_src) disable iff (!rst_n)
    (!mode_strap && !shared_pin_n[1]) |=> (req_pci == '0)); // R3
  AST_PCIF_FREE: assert property (@(posedge pci_src) disable iff (!rst_n)
    (!mode_strap && !shared_pin_n[1] && shared_pin_n[3] && en_pcif) |=> req_pcif); // R3
  AST_SDR_STOP: assert property (@(posedge pci_src) disable iff (!rst_n)
    (!mode_strap && !shared_pin_n[2]) |=> (req_sdr == '0)); // R4
  AST_PD_ALL: assert property (@(posedge pci_src) disable iff (!rst_n)
    (!mode_strap && !shared_pin_n[3]) |=> ({req_cpu, req_pcif, req_pci, req_sdr, req_ref} == '0)); // R5
  AST_STRAP_IGNORE: assert property (@(posedge pci_src) disable iff (!rst_n)
    mode_strap |=> (req_cpu == $past(en_cpu))); // R6
  AST_SHARED_OFF: assert property (@(posedge pci_src) disable iff (!rst_n)
    !mode_strap |=> (req_sdr[SHR_LO +: SHR_COUNT] == '0)); // R6
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
  parameter int W = 1
) (
  input  logic         src,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  output logic [W-1:0] clk_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic gate_q;        // enable seen by the AND gate
    logic gate_at_rise;  // gate value observed at the rising edge
    // update only on the falling edge, so the gate moves while src is low
    always_ff @(negedge src or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= req[g];
    end
    always_ff @(posedge src or negedge rst_n) begin
      if (!rst_n) gate_at_rise <= 1'b0;
      else        gate_at_rise <= gate_q;
    end
    assign clk_o[g] = src & gate_q;

    AST_GATE_LOW_PHASE: assert property (@(negedge src) disable iff (!rst_n)
      gate_q == gate_at_rise); // R7
  end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
  parameter int N_CPU  = 3,
  parameter int N_PCI  = 5,
  parameter int N_SDR  = 13,
  parameter int N_REF  = 4,
  parameter int SHR_LO = 8
) (
  input  logic             rst_n,
  input  logic             cpu_src,
  input  logic             pci_src,
  input  logic             sdr_src,
  input  logic             ref_src,
  input  logic             mode_strap,
  input  logic [3:0]       shared_pin_n,
  input  logic             tri_en,
  input  logic [N_CPU-1:0] en_cpu,
  input  logic             en_pcif,
  input  logic [N_PCI-1:0] en_pci,
  input  logic [N_SDR-1:0] en_sdr,
  input  logic [N_REF-1:0] en_ref,
  output logic [N_CPU-1:0] cpu_clk,
  output logic             pcif_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic [N_SDR-1:0] sdr_clk,
  output logic [N_REF-1:0] ref_clk,
  output logic             cpu_oe,
  output logic             pcif_oe,
  output logic             pci_oe,
  output logic [N_SDR-1:0] sdr_oe,
  output logic             ref_oe
);
  import clkstop_pkg::*;

  logic [N_CPU-1:0] req_cpu;
  logic             req_pcif;
  logic [N_PCI-1:0] req_pci;
  logic [N_SDR-1:0] req_sdr;
  logic [N_REF-1:0] req_ref;

  clkstop_sample #(
    .N_CPU(N_CPU), .N_PCI(N_PCI), .N_SDR(N_SDR), .N_REF(N_REF), .SHR_LO(SHR_LO)
  ) u_sample (
    .pci_src(pci_src), .rst_n(rst_n), .mode_strap(mode_strap), .shared_pin_n(shared_pin_n),
    .en_cpu(en_cpu), .en_pcif(en_pcif), .en_pci(en_pci), .en_sdr(en_sdr), .en_ref(en_ref),
    .req_cpu(req_cpu), .req_pcif(req_pcif), .req_pci(req_pci), .req_sdr(req_sdr), .req_ref(req_ref)
  );

  clkstop_gate #(.W(N_CPU)) u_gate_cpu (.src(cpu_src), .rst_n(rst_n), .req(req_cpu),  .clk_o(cpu_clk));
  clkstop_gate #(.W(1))     u_gate_pcif(.src(pci_src), .rst_n(rst_n), .req(req_pcif), .clk_o(pcif_clk));
  clkstop_gate #(.W(N_PCI)) u_gate_pci (.src(pci_src), .rst_n(rst_n), .req(req_pci),  .clk_o(pci_clk));
  clkstop_gate #(.W(N_SDR)) u_gate_sdr (.src(sdr_src), .rst_n(rst_n), .req(req_sdr),  .clk_o(sdr_clk));
  clkstop_gate #(.W(N_REF)) u_gate_ref (.src(ref_src), .rst_n(rst_n), .req(req_ref),  .clk_o(ref_clk));

  // output enables: tristate drops all, shared memory slots drive only with strap at 1
  assign cpu_oe  = !tri_en;
  assign pcif_oe = !tri_en;
  assign pci_oe  = !tri_en;
  assign ref_oe  = !tri_en;
  for (genvar g = 0; g < N_SDR; g++) begin : g_sdr_oe
    if (in_shared(g, SHR_LO)) begin : g_shr
      assign sdr_oe[g] = !tri_en && mode_strap;
    end else begin : g_own
      assign sdr_oe[g] = !tri_en;
    end
  end
endmodule

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;
  localparam int NC = 3, NP = 5, NS = 13, NR = 4, SLO = 8;
  localparam int OC = 0, OF = NC, OP = NC + 1, OS = OP + NP, OR = OS + NS, NT = OR + NR;
  localparam int NOE = NS + 4;

  logic rst_n = 1'b0;
  logic cpu_src = 1'b0, pci_src = 1'b0, sdr_src = 1'b0, ref_src = 1'b0;
  always #5  cpu_src = ~cpu_src;   // 100 MHz
  always #15 pci_src = ~pci_src;
  always #10 sdr_src = ~sdr_src;
  always #35 ref_src = ~ref_src;

  logic          mode = 1'b1;
  logic [3:0]    pins = 4'hF;
  logic          tri_en = 1'b0;
  logic [NC-1:0] en_cpu = '1;
  logic          en_pcif = 1'b1;
  logic [NP-1:0] en_pci = '1;
  logic [NS-1:0] en_sdr = '1;
  logic [NR-1:0] en_ref = '1;

  logic [NC-1:0] cpu_clk;
  logic          pcif_clk;
  logic [NP-1:0] pci_clk;
  logic [NS-1:0] sdr_clk;
  logic [NR-1:0] ref_clk;
  logic cpu_oe, pcif_oe, pci_oe, ref_oe;
  logic [NS-1:0] sdr_oe;

  clkstop_ctrl u_clkstop_ctrl (
    .rst_n(rst_n), .cpu_src(cpu_src), .pci_src(pci_src), .sdr_src(sdr_src), .ref_src(ref_src),
    .mode_strap(mode), .shared_pin_n(pins), .tri_en(tri_en),
    .en_cpu(en_cpu), .en_pcif(en_pcif), .en_pci(en_pci), .en_sdr(en_sdr), .en_ref(en_ref),
    .cpu_clk(cpu_clk), .pcif_clk(pcif_clk), .pci_clk(pci_clk), .sdr_clk(sdr_clk), .ref_clk(ref_clk),
    .cpu_oe(cpu_oe), .pcif_oe(pcif_oe), .pci_oe(pci_oe), .sdr_oe(sdr_oe), .ref_oe(ref_oe)
  );

  wire [NT-1:0]  all_clk = {ref_clk, sdr_clk, pci_clk, pcif_clk, cpu_clk};
  wire [NT-1:0]  en_all  = {en_ref, en_sdr, en_pci, en_pcif, en_cpu};
  wire [NOE-1:0] oe_all  = {ref_oe, sdr_oe, pci_oe, pcif_oe, cpu_oe};

  int checks = 0, errors = 0;
  int rises [NT];
  int hlen  [NT];
  bit armed [NT];
  int pulses = 0;
  logic [NT-1:0] prev = '0;
  bit done = 0;

  function automatic int half_of(int i);
    if (i < OF) return 5;
    if (i < OS) return 15;
    if (i < OR) return 10;
    return 35;
  endfunction

  function automatic bit exp_run(int i);
    bit pdok = mode || pins[3];
    if (i < OF)  return en_all[i] && pdok && (mode || pins[0]);
    if (i == OF) return en_all[i] && pdok;
    if (i < OS)  return en_all[i] && pdok && (mode || pins[1]);
    if (i < OR)  return en_all[i] && pdok && (mode || pins[2]) &&
                        (mode || !((i - OS) >= SLO && (i - OS) < SLO + 4));
    return en_all[i] && pdok;
  endfunction

  function automatic logic [NOE-1:0] exp_oe();
    logic [NS-1:0] s = '1;
    if (!mode) s[SLO +: 4] = '0;
    if (tri_en) return '0;
    return {1'b1, s, 1'b1, 1'b1, 1'b1};
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // R7 pulse-width monitor, sampling between clock edges
  initial begin
    for (int i = 0; i < NT; i++) begin rises[i] = 0; hlen[i] = 0; armed[i] = 0; end
    #0.5;
    forever begin
      for (int i = 0; i < NT; i++) begin
        if (all_clk[i] === 1'b1) begin
          if (!prev[i]) rises[i]++;
          hlen[i]++;
        end else begin
          if (prev[i] && armed[i]) begin
            pulses++;
            if (hlen[i] != half_of(i))
              check(1'b0, "R7", $sformatf("out%0d high width", i), hlen[i], half_of(i));
          end
          armed[i] = 1; hlen[i] = 0;
        end
      end
      prev = all_clk;
      #1;
    end
  end

  task automatic apply(input logic m, input logic [3:0] p, input logic t);
    @(negedge pci_src); #0.2;
    mode = m; pins = p; tri_en = t;
  endtask

  task automatic verify(input string tag);
    int r0 [NT];
    #150;
    for (int i = 0; i < NT; i++) r0[i] = rises[i];
    #160;
    for (int i = 0; i < NT; i++) begin
      bit run = (rises[i] - r0[i]) > 0;
      bit ex  = exp_run(i);
      check((run == ex) && (ex || all_clk[i] == 1'b0), tag, $sformatf("out%0d running", i), run, ex);
    end
    check(oe_all == exp_oe(), tag, "output enables", oe_all, exp_oe());
  endtask

  initial begin
    #100000;
    if (!done) begin
      check(1'b0, "watchdog", "run completed", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r, rf;
    void'($urandom(32'h1c5a7));
    #60.2;
    check(all_clk == '0, "R10", "outputs low in reset", all_clk, 0);
    rst_n = 1'b1;
    verify("R10");
    // R6: strap at 1 ignores all-low pins
    apply(1'b1, 4'h0, 1'b0); verify("R6");
    // R6: strap at 0 parks the shared memory slots
    apply(1'b0, 4'hF, 1'b0); verify("R6");
    // R2, R3, R4 stops one by one
    apply(1'b0, 4'b1110, 1'b0); verify("R2");
    apply(1'b0, 4'b1101, 1'b0); verify("R3");
    apply(1'b0, 4'b1011, 1'b0); verify("R4");
    // R5: power-down overrides everything
    apply(1'b0, 4'b0111, 1'b0); verify("R5");
    // R1: single enables off
    en_cpu[1] = 1'b0; en_sdr[0] = 1'b0; en_ref[2] = 1'b0; en_pcif = 1'b0;
    apply(1'b0, 4'hF, 1'b0); verify("R1");
    en_cpu = '1; en_sdr = '1; en_ref = '1; en_pcif = 1'b1;
    // R9: tristate
    apply(1'b1, 4'hF, 1'b1); verify("R9");
    apply(1'b0, 4'hF, 1'b0); verify("R8");
    // R8: processor stop and restart latency
    apply(1'b0, 4'b1110, 1'b0);
    @(posedge pci_src); #20.1; r = rises[OC]; #60;
    check(rises[OC] == r && cpu_clk[0] == 1'b0, "R8", "cpu stopped by 2 periods", rises[OC] - r, 0);
    apply(1'b0, 4'b1111, 1'b0);
    @(posedge pci_src); r = rises[OC]; #20.6;
    check(rises[OC] - r >= 1, "R8", "cpu restarted by 2 periods", rises[OC] - r, 1);
    // R8: bus group stop and restart at the next bus edge; R3 free clock unaffected
    apply(1'b0, 4'b1101, 1'b0);
    @(posedge pci_src); #0.6; r = rises[OP]; rf = rises[OF]; #30.5;
    check(rises[OP] == r, "R8", "bus stopped at next edge", rises[OP] - r, 0);
    check(rises[OF] - rf == 1, "R3", "free bus clock kept running", rises[OF] - rf, 1);
    apply(1'b0, 4'b1111, 1'b0);
    @(posedge pci_src); #0.6; r = rises[OP]; #30.5;
    check(rises[OP] - r == 1, "R8", "bus restarted at next edge", rises[OP] - r, 1);
    // R1 random mix
    for (int k = 0; k < 40; k++) begin
      en_cpu = NC'($urandom); en_pci = NP'($urandom); en_sdr = NS'($urandom);
      en_ref = NR'($urandom); en_pcif = ($urandom % 4) != 0;
      apply(($urandom % 4) == 0,
            {($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 3) != 0},
            ($urandom % 5) == 0);
      verify("R1");
    end
    check(pulses > 0, "R7", "pulses measured", pulses, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule